// File: doc/BRIEF.md
# Zoned/Packed Decimal Field Converter

This block converts a signed decimal field in either direction between two storage forms. In the zoned form, each byte holds one digit in its low nibble and a zone in its high nibble, and the zone of the least significant byte holds the sign. In the packed form, each byte holds two digits, and the low nibble of the least significant byte holds the sign. A caller pulses `start` together with the direction, the zone convention and the source and destination lengths in bytes. The block then requests source bytes one at a time, least significant first, through `in_req`. It emits destination bytes, also least significant first, on `out_byte` qualified by `out_valid`.

The block checks every digit nibble and the sign code while it converts. It always writes the sign in canonical form. If the destination has room for more digits than the source supplies, the block fills the extra positions with zeros. If the destination is shorter, the block drops the excess high digits without flagging anything. When the operation ends, `done` pulses once and `dexc` reports whether any invalid digit or sign was seen.

Top module: `dec_field_conv`

## Requirements
- R1: After reset, `busy`, `done`, `out_valid`, `in_req` and `dexc` are all 0.
- R2: In packing (`op_unpack`=0), destination byte 0 is {digit0, sign}. Destination byte k (k≥1) is {digit 2k, digit 2k−1}. Here digit i is the low nibble of source byte i.
- R3: The output sign is 1101 when the source sign code is 1011 or 1101. For the codes 1010, 1100, 1110 and 1111 it is 1100. This holds in both directions and both zone conventions.
- R4: In unpacking (`op_unpack`=1), source byte 0 is {digit0, sign} and source byte m (m≥1) is {digit 2m, digit 2m−1}. Destination byte 0 is {canonical sign, digit0}. Destination byte k≥1 is {zone, digit k}, where the zone is 0011 when `ascii_mode`=1 and 1111 when `ascii_mode`=0.
- R5: Digit positions beyond those the source supplies are emitted as digit 0, with the normal zone in unpacking.
- R6: A destination shorter than the source truncates the high digits. Exactly `dst_len` bytes are emitted, and truncation alone does not set `dexc`.
- R7: `dexc` is 1 at `done` if any source digit nibble is above 1001 or the sign code is below 1010. It is cleared by an accepted `start` and otherwise holds its value while the block is idle.
- R8: An operation issues exactly `src_len` input requests and emits exactly `dst_len` output bytes. `done` is a one-cycle pulse and `busy` is 0 while `done` is high.
- R9: `done` rises exactly N cycles after the accepted `start` edge. N is max(src_len, 2·dst_len−1) for packing and max(dst_len, 2·src_len−1) for unpacking. A length of 0 is treated as 1.
- R10: A `start` pulse while `busy` is 1 is ignored, and the running operation completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse, accepted only when idle |
| op_unpack | input | 1 | 0 = packing, 1 = unpacking |
| ascii_mode | input | 1 | Zone convention: 1 = 0011 zones, 0 = 1111 zones |
| src_len | input | LW | Source field length in bytes (1..MAX_LEN) |
| dst_len | input | LW | Destination field length in bytes (1..MAX_LEN) |
| in_byte | input | 8 | Source byte, sampled at the edge ending a cycle with `in_req` high |
| in_req | output | 1 | The block consumes `in_byte` at the coming edge |
| out_valid | output | 1 | `out_byte` holds a new destination byte |
| out_byte | output | 8 | Destination byte, least significant first |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| dexc | output | 1 | Data exception status of the last operation |

## Verification
Step k of an operation occupies the k-th cycle after the accepted `start` edge. During that cycle, a high `in_req` means the source byte must be present before the following edge, and any byte produced by that step appears registered just after that edge. The bench answers `in_req` and collects `out_valid` on the falling edge, so each request is served within the same cycle and each output is read one edge after its step. Because `done` and `dexc` are registered at the edge that ends the last step, the bench counts falling edges from launch and requires `done` exactly at the count given in R9, with `dexc` compared in that same sample.

// File: rtl/dec_conv_pkg.sv
package dec_conv_pkg;
   localparam logic [3:0] ZONE_ASCII  = 4'h3;
   localparam logic [3:0] ZONE_EBCDIC = 4'hF;
   localparam logic [3:0] SIGN_PLUS   = 4'hC;
   localparam logic [3:0] SIGN_MINUS  = 4'hD;
   localparam logic [3:0] DIGIT_MAX   = 4'h9;
   localparam logic [3:0] SIGN_MIN    = 4'hA;

   typedef enum logic {CONV_PACK = 1'b0, CONV_UNPACK = 1'b1} conv_dir_e;

   function automatic logic nib_is_digit(input logic [3:0] n);
      return n <= DIGIT_MAX;
   endfunction
endpackage

// File: rtl/dec_sign_unit.sv
module dec_sign_unit
   import dec_conv_pkg::*;
(
   input  logic [3:0] code,
   output logic       legal,
   output logic [3:0] canon
);
   always_comb begin
      legal = code >= SIGN_MIN;
      canon = (code == 4'hB || code == 4'hD) ? SIGN_MINUS : SIGN_PLUS;
   end
endmodule

// File: rtl/dec_step_ctrl.sv
module dec_step_ctrl #(
   parameter int SW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          launch,
   input  logic [SW-1:0] total,
   output logic          busy,
   output logic [SW-1:0] step,
   output logic          last
);
   assign last = busy && (step == total - SW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         step <= '0;
      end else if (launch) begin
         busy <= 1'b1;
         step <= '0;
      end else if (busy) begin
         if (last) busy <= 1'b0;
         else      step <= step + SW'(1);
      end
   end
endmodule

// File: rtl/dec_field_conv.sv
module dec_field_conv
   import dec_conv_pkg::*;
#(
   parameter int MAX_LEN = 16,
   localparam int LW = $clog2(MAX_LEN + 1),
   localparam int SW = $clog2(2 * MAX_LEN + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          op_unpack,
   input  logic          ascii_mode,
   input  logic [LW-1:0] src_len,
   input  logic [LW-1:0] dst_len,
   input  logic [7:0]    in_byte,
   output logic          in_req,
   output logic          out_valid,
   output logic [7:0]    out_byte,
   output logic          busy,
   output logic          done,
   output logic          dexc
);
   generate
      if (MAX_LEN < 1) begin : g_len_bad
         $error("dec_field_conv: MAX_LEN must be at least 1");
      end
   endgenerate

   conv_dir_e     dir_q;
   logic          ascii_q;
   logic [LW-1:0] src_q, dst_q;
   logic [SW-1:0] src_w, dst_w, total, step, half, pk_span, up_span;
   logic          launch, last, rd_now;
   logic [3:0]    held_q, held_nx, dig, zone, sign_code, sign_canon;
   logic          sign_legal, bad, out_en;
   logic [7:0]    out_nx;

   function automatic logic [LW-1:0] clamp_len(input logic [LW-1:0] l);
      if (l == '0)                        return LW'(1);
      else if (32'(l) > MAX_LEN)          return LW'(MAX_LEN);
      else                                return l;
   endfunction

   assign launch  = start && !busy;
   assign src_w   = SW'(src_q);
   assign dst_w   = SW'(dst_q);
   assign pk_span = (dst_w << 1) - SW'(1);
   assign up_span = (src_w << 1) - SW'(1);
   assign total   = (dir_q == CONV_PACK) ? ((src_w > pk_span) ? src_w : pk_span)
                                         : ((dst_w > up_span) ? dst_w : up_span);
   assign half    = (step + SW'(1)) >> 1;
   assign zone    = ascii_q ? ZONE_ASCII : ZONE_EBCDIC;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q   <= CONV_PACK;
         ascii_q <= 1'b0;
         src_q   <= LW'(1);
         dst_q   <= LW'(1);
      end else if (launch) begin
         dir_q   <= op_unpack ? CONV_UNPACK : CONV_PACK;
         ascii_q <= ascii_mode;
         src_q   <= clamp_len(src_len);
         dst_q   <= clamp_len(dst_len);
      end
   end

   dec_step_ctrl #(.SW(SW)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .launch(launch), .total(total),
      .busy(busy), .step(step), .last(last)
   );

   assign sign_code = (dir_q == CONV_UNPACK) ? in_byte[3:0] : in_byte[7:4];

   dec_sign_unit u_sign (.code(sign_code), .legal(sign_legal), .canon(sign_canon));

   always_comb begin
      if (dir_q == CONV_PACK) rd_now = step < src_w;
      else                    rd_now = ((step == '0) || step[0]) && (half < src_w);
   end
   assign in_req = busy && rd_now;

   always_comb begin
      dig     = 4'h0;
      held_nx = held_q;
      out_en  = 1'b0;
      out_nx  = 8'h00;
      bad     = 1'b0;
      if (dir_q == CONV_PACK) begin
         dig = rd_now ? in_byte[3:0] : 4'h0;
         bad = (rd_now && !nib_is_digit(in_byte[3:0])) || ((step == '0) && !sign_legal);
         if (step[0]) begin
            held_nx = dig;
         end else if ((step >> 1) < dst_w) begin
            out_en = 1'b1;
            out_nx = {dig, (step == '0) ? sign_canon : held_q};
         end
      end else begin
         if (step == '0) begin
            dig = in_byte[7:4];
            bad = !nib_is_digit(in_byte[7:4]) || !sign_legal;
         end else if (step[0]) begin
            if (rd_now) begin
               dig     = in_byte[3:0];
               held_nx = in_byte[7:4];
               bad     = !nib_is_digit(in_byte[3:0]) || !nib_is_digit(in_byte[7:4]);
            end else begin
               dig     = 4'h0;
               held_nx = 4'h0;
            end
         end else begin
            dig = held_q;
         end
         if (step < dst_w) begin
            out_en = 1'b1;
            out_nx = {(step == '0) ? sign_canon : zone, dig};
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_q    <= 4'h0;
         out_valid <= 1'b0;
         out_byte  <= 8'h00;
         done      <= 1'b0;
         dexc      <= 1'b0;
      end else if (launch) begin
         held_q    <= 4'h0;
         out_valid <= 1'b0;
         done      <= 1'b0;
         dexc      <= 1'b0;
      end else if (busy) begin
         held_q    <= held_nx;
         out_valid <= out_en;
         if (out_en) out_byte <= out_nx;
         done      <= last;
         dexc      <= dexc | bad;
      end else begin
         out_valid <= 1'b0;
         done      <= 1'b0;
      end
   end
endmodule

// File: rtl/dec_field_conv_chk.sv
module dec_field_conv_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       start,
   input logic       busy,
   input logic       done,
   input logic       in_req,
   input logic       out_valid,
   input logic [7:0] out_byte,
   input logic       dexc,
   input logic       unpack_q
);
   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
   // R8
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
   // R8
   req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) in_req |-> busy);
   // R7
   dexc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(dexc));
   // R10
   out_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (busy || done));
   // R4
   unpack_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && unpack_q && !dexc) |-> (out_byte[3:0] <= 4'h9));
endmodule

bind dec_field_conv dec_field_conv_chk u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
   .in_req(in_req), .out_valid(out_valid), .out_byte(out_byte), .dexc(dexc),
   .unpack_q(dir_q == dec_conv_pkg::CONV_UNPACK)
);

// File: tb/dec_field_conv_tb.sv
module dec_field_conv_tb;
   localparam int ML = 16;
   localparam int LW = $clog2(ML + 1);

   logic clk = 0, rst_n = 0, start = 0, op_unpack = 0, ascii_mode = 0;
   logic [LW-1:0] src_len = 1, dst_len = 1;
   logic [7:0] in_byte = 0, out_byte;
   logic in_req, out_valid, busy, done, dexc;

   always #10 clk = ~clk;

   dec_field_conv #(.MAX_LEN(ML)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .op_unpack(op_unpack),
      .ascii_mode(ascii_mode), .src_len(src_len), .dst_len(dst_len),
      .in_byte(in_byte), .in_req(in_req), .out_valid(out_valid),
      .out_byte(out_byte), .busy(busy), .done(done), .dexc(dexc)
   );

   int checks = 0, errors = 0;
   logic [7:0] src [ML];
   logic [7:0] expv[ML];
   logic [7:0] got [ML];
   logic       exp_exc;

   task automatic chk(input bit ok, input string req, input int act, input int expd);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, expd);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   function automatic logic [3:0] canon(input logic [3:0] c);
      return (c == 4'hB || c == 4'hD) ? 4'hD : 4'hC;
   endfunction

   function automatic logic [3:0] digit_at(input bit up, input int sl, input int i);
      if (!up) return (i < sl) ? src[i][3:0] : 4'h0;
      if (i == 0) return src[0][7:4];
      if (((i + 1) / 2) >= sl) return 4'h0;
      return (i % 2 == 1) ? src[(i + 1) / 2][3:0] : src[i / 2][7:4];
   endfunction

   task automatic model(input bit up, input bit asc, input int sl, input int dl);
      exp_exc = 0;
      for (int i = 0; i < sl; i++) begin
         if (!up) exp_exc |= (src[i][3:0] > 9) || (i == 0 && src[0][7:4] < 4'hA);
         else if (i == 0) exp_exc |= (src[0][7:4] > 9) || (src[0][3:0] < 4'hA);
         else exp_exc |= (src[i][3:0] > 9) || (src[i][7:4] > 9);
      end
      for (int k = 0; k < dl; k++) begin
         if (!up) expv[k] = {digit_at(0, sl, 2 * k),
                             (k == 0) ? canon(src[0][7:4]) : digit_at(0, sl, 2 * k - 1)};
         else     expv[k] = {(k == 0) ? canon(src[0][3:0]) : (asc ? 4'h3 : 4'hF),
                             digit_at(1, sl, k)};
      end
   endtask

   task automatic run_op(input bit up, input bit asc, input int sl, input int dl,
                         input bit poke, input string tag);
      int c = 0, ptr = 0, nout = 0, total;
      bit seen = 0;
      model(up, asc, sl, dl);
      total = up ? ((dl > 2 * sl - 1) ? dl : 2 * sl - 1)
                 : ((sl > 2 * dl - 1) ? sl : 2 * dl - 1);
      @(negedge clk);
      op_unpack = up; ascii_mode = asc; src_len = LW'(sl); dst_len = LW'(dl); start = 1;
      while (!seen && c < 100) begin
         @(negedge clk);
         start = 0;
         if (poke && c == 1) begin
            start = 1; op_unpack = !up; src_len = 1; dst_len = 1;
         end
         if (out_valid) begin
            if (nout < ML) got[nout] = out_byte;
            nout++;
         end
         if (done) begin
            seen = 1;
            chk(c == total, "R9 cycles", c, total);
         end else if (in_req) begin
            in_byte = src[ptr % ML];
            ptr++;
            c++;
         end else c++;
      end
      chk(seen, "R8 done", seen, 1);
      chk(ptr == sl, "R8 reads", ptr, sl);
      chk(nout == dl, {tag, " R8 count"}, nout, dl);
      for (int k = 0; k < dl && k < nout; k++)
         chk(got[k] === expv[k], tag, got[k], expv[k]);
      chk(dexc === exp_exc, "R7 dexc", dexc, exp_exc);
      @(negedge clk);
      chk(!done && !busy, "R8 pulse", done, 0);
   endtask

   task automatic fill_valid(input bit up, input logic [3:0] sgn, input int sl);
      for (int i = 0; i < sl; i++) begin
         if (!up) src[i] = {(i == 0) ? sgn : 4'($urandom_range(15)), 4'($urandom_range(9))};
         else     src[i] = {4'($urandom_range(9)), (i == 0) ? sgn : 4'($urandom_range(9))};
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      chk(0, "watchdog", 0, 1);
      summary();
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      chk(!busy && !done && !out_valid && !in_req && !dexc, "R1 reset", {busy, done, out_valid, in_req, dexc}, 0);
      rst_n = 1;
      // R3 minus code 1011 packs to 1101, plus 1111 unpacks to 1100
      fill_valid(0, 4'hB, 3); run_op(0, 0, 3, 2, 0, "R3 pack minus");
      fill_valid(1, 4'hF, 2); run_op(1, 0, 2, 3, 0, "R3 unpack plus");
      fill_valid(1, 4'hB, 3); run_op(1, 1, 3, 5, 0, "R4 ascii zone");
      fill_valid(1, 4'hC, 3); run_op(1, 0, 3, 5, 0, "R4 ebcdic zone");
      fill_valid(0, 4'hD, 1); run_op(0, 0, 1, 4, 0, "R5 pack fill");
      fill_valid(1, 4'hA, 1); run_op(1, 1, 1, 5, 0, "R5 unpack fill");
      fill_valid(0, 4'hC, 8); run_op(0, 0, 8, 2, 0, "R6 pack trunc");
      fill_valid(1, 4'hD, 4); run_op(1, 0, 4, 3, 0, "R6 unpack trunc");
      fill_valid(0, 4'hC, 4); src[2][3:0] = 4'hB; run_op(0, 0, 4, 3, 0, "R7 bad digit");
      fill_valid(1, 4'h7, 2); run_op(1, 0, 2, 3, 0, "R7 bad sign");
      repeat (3) @(negedge clk);
      chk(dexc === 1'b1, "R7 idle hold", dexc, 1);
      fill_valid(0, 4'hE, 5); run_op(0, 1, 5, 3, 1, "R10 start ignored");
      fill_valid(0, 4'hC, ML); run_op(0, 0, ML, ML, 0, "R2 full");
      for (int n = 0; n < 150; n++) begin
         bit up = 1'($urandom_range(1));
         int sl = $urandom_range(1, ML), dl = $urandom_range(1, ML);
         fill_valid(up, 4'($urandom_range(10, 15)), sl);
         if ($urandom_range(9) == 0) src[$urandom_range(sl - 1)] = 8'($urandom);
         run_op(up, 1'($urandom_range(1)), sl, dl, 0, up ? "R4 rand" : "R2 rand");
      end
      summary();
   end
endmodule